// File: doc/BRIEF.md
# Raster-Operation Rectangle Blitter

The block moves a rectangle of bytes inside a local video memory. The rectangle starts at one address in a source region and at another in a destination region. For every byte it reads the source byte and the destination byte, combines them under a selected boolean raster operation, and writes the result back to the destination. A caller supplies an operation code, a mode byte, two start addresses, two signed row pitches, a width in bytes and a height in rows, and then pulses `start`. The block drives a single byte-wide port to a synchronous RAM with one cycle of read latency. When the transfer is over, it raises `done` for one cycle.

Rows can be walked in one of two directions. In forward mode the bytes in a row are visited at rising addresses, and each row start moves by the pitch. In backward mode the start addresses name the last byte of the rectangle. The bytes in a row are then visited at falling addresses, and each row start moves by the negated pitch, which lets overlapping regions be copied safely. A request with an unknown operation code, an unsupported pixel-size field, or an empty rectangle finishes at once and does not touch memory.

Top module: `blit_engine`

## Requirements
- R1: The operation code selects the destination result per bit, with s the source byte and d the destination byte: 0x00 gives 0; 0x05 gives s&d; 0x06 gives d; 0x09 gives s&~d; 0x0B gives ~d; 0x0D gives s; 0x0E gives 0xFF; 0x50 gives ~s&d; 0x59 gives s^d; 0x6D gives s|d; 0x90 gives ~s|~d; 0x95 gives ~(s^d); 0xAD gives s|~d; 0xD0 gives ~s; 0xD6 gives ~s|d; 0xDA gives ~s&~d.
- R2: A start with any other operation code is refused. `done` is high in the cycle after the start cycle, `busy` stays low and memory is not accessed.
- R3: Mode bit 0 selects backward walking when it is 1. Mode bits 3:1 give the pixel size code, and only the values 0 to 3 are accepted. Values 4 to 7 are refused exactly as in R2.
- R4: A start with a width of zero or a height of zero completes as in R2, with no memory access.
- R5: Each byte takes exactly three RAM cycles, in this order: a read at the source pointer, a read at the destination pointer, and a write of the result at the destination pointer. For W×H bytes, `done` goes high 3·W·H+1 cycles after the start cycle.
- R6: In forward mode, byte x of row y is taken from src+y·spitch+x and written to dst+y·dpitch+x, with signed pitches and addresses wrapping modulo the memory size.
- R7: In backward mode, byte x of row y is taken from src−y·spitch−x and written to dst−y·dpitch−x.
- R8: Code 0x06 writes back the destination byte unchanged, so memory does not change.
- R9: After an accepted start, `busy` is high from the next cycle until the last write. `done` is a single-cycle pulse in the cycle after that write, with `busy` low.
- R10: A start while `busy` is high is ignored. The running transfer completes unchanged and no second transfer follows.
- R11: During and after reset, `busy`, `done`, `mem_en` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a transfer (sampled while idle) |
| rop_code | input | 8 | Raster operation code |
| mode | input | 8 | Bit 0 backward, bits 3:1 pixel size code |
| src_addr | input | ADDR_W | Source start address |
| dst_addr | input | ADDR_W | Destination start address |
| src_pitch | input | PITCH_W | Signed source row pitch |
| dst_pitch | input | PITCH_W | Signed destination row pitch |
| width | input | DIM_W | Bytes per row |
| height | input | DIM_W | Row count |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each of the sixteen codes is run over one row that holds all four source/destination bit combinations. This separates every truth table from its neighbours, including the no-op case. Multi-row copies with positive pitch, negative pitch and backward mode show whether the row stride, its sign and the direction within a row are applied to both pointers. A scoreboard checks the order of every RAM access, so an error in the three-phase sequence is caught. Refused requests (unknown code, pixel code 5, zero width, zero height) and a start pulse during a busy transfer must produce no access at all, and they must finish on the cycle counts given in R2 and R5.

// File: rtl/blit_pkg.sv
// Package: shared types and the operation-code decoder for the blitter.
// Assumes byte-wide data; truth tables are indexed by {src_bit, dst_bit}.
package blit_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RSRC = 2'd1,
        ST_RDST = 2'd2,
        ST_WRITE = 2'd3
    } blit_state_e;

    typedef struct packed {
        logic       known;
        logic [3:0] table_bits;
    } rop_dec_t;

    // Map an 8-bit raster-op code to a 2-input truth table.
    function automatic rop_dec_t rop_decode(input logic [7:0] code);
        rop_dec_t r;
        r.known = 1'b1;
        case (code)
            8'h00: r.table_bits = 4'b0000;
            8'h05: r.table_bits = 4'b1000;
            8'h06: r.table_bits = 4'b1010;
            8'h09: r.table_bits = 4'b0100;
            8'h0B: r.table_bits = 4'b0101;
            8'h0D: r.table_bits = 4'b1100;
            8'h0E: r.table_bits = 4'b1111;
            8'h50: r.table_bits = 4'b0010;
            8'h59: r.table_bits = 4'b0110;
            8'h6D: r.table_bits = 4'b1110;
            8'h90: r.table_bits = 4'b0111;
            8'h95: r.table_bits = 4'b1001;
            8'hAD: r.table_bits = 4'b1101;
            8'hD0: r.table_bits = 4'b0011;
            8'hD6: r.table_bits = 4'b1011;
            8'hDA: r.table_bits = 4'b0001;
            default: begin
                r.known = 1'b0;
                r.table_bits = 4'b1010;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/blit_rop_alu.sv
// Module: bitwise raster-op combiner.
// Each result bit is a lookup of the 4-entry truth table at {src_bit, dst_bit}.
// Purely combinational; assumes table_bits is stable while in use.
module blit_rop_alu #(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        table_bits,
    input  logic [DATA_W-1:0] src_byte,
    input  logic [DATA_W-1:0] dst_byte,
    output logic [DATA_W-1:0] result
);
    // One truth-table lookup per bit lane.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign result[i] = table_bits[{src_byte[i], dst_byte[i]}];
    end
endmodule

// File: rtl/blit_walker.sv
// Module: rectangle address walker.
// On load it latches the bases, pitches, size and direction. Each step moves
// to the next byte: +/-1 within a row, and row base +/- pitch at a row end.
// Assumes width and height are non-zero when loaded; addresses wrap.
module blit_walker #(
    parameter int ADDR_W  = 10,
    parameter int PITCH_W = 11,
    parameter int DIM_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               backward,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    output logic [ADDR_W-1:0]  src_ptr,
    output logic [ADDR_W-1:0]  dst_ptr,
    output logic               last
);
    localparam logic [DIM_W-1:0] ONE_D = DIM_W'(1);

    logic [ADDR_W-1:0]  src_row, dst_row;
    logic [ADDR_W-1:0]  src_stride, dst_stride;
    logic [DIM_W-1:0]   xcnt, ycnt, w_q, h_q;
    logic               bwd_q;
    logic [PITCH_W-1:0] sp_eff, dp_eff;
    logic               row_end;
    logic [ADDR_W-1:0]  src_row_nx, dst_row_nx;

    // Effective strides: pitches negated in backward mode, truncated to address width.
    always_comb begin
        sp_eff     = backward ? -src_pitch : src_pitch;
        dp_eff     = backward ? -dst_pitch : dst_pitch;
        row_end    = (xcnt == w_q - ONE_D);
        last       = row_end && (ycnt == h_q - ONE_D);
        src_row_nx = src_row + src_stride;
        dst_row_nx = dst_row + dst_stride;
    end

    // Pointer and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_row <= '0; dst_row <= '0; src_ptr <= '0; dst_ptr <= '0;
            src_stride <= '0; dst_stride <= '0;
            xcnt <= '0; ycnt <= '0; w_q <= '0; h_q <= '0; bwd_q <= 1'b0;
        end else if (load) begin
            src_row    <= src_base;
            dst_row    <= dst_base;
            src_ptr    <= src_base;
            dst_ptr    <= dst_base;
            src_stride <= sp_eff[ADDR_W-1:0];
            dst_stride <= dp_eff[ADDR_W-1:0];
            xcnt <= '0; ycnt <= '0;
            w_q <= width; h_q <= height; bwd_q <= backward;
        end else if (step) begin
            if (row_end) begin
                xcnt    <= '0;
                ycnt    <= ycnt + ONE_D;
                src_row <= src_row_nx;
                dst_row <= dst_row_nx;
                src_ptr <= src_row_nx;
                dst_ptr <= dst_row_nx;
            end else begin
                xcnt    <= xcnt + ONE_D;
                src_ptr <= bwd_q ? src_ptr - 1'b1 : src_ptr + 1'b1;
                dst_ptr <= bwd_q ? dst_ptr - 1'b1 : dst_ptr + 1'b1;
            end
        end
    end

    // Within a row the destination pointer moves by exactly one in the walk direction.
    assert_row_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !row_end) |=>
            (dst_ptr == ($past(bwd_q) ? $past(dst_ptr) - 1'b1 : $past(dst_ptr) + 1'b1)));

    // Source and destination stay in lockstep inside a row (same byte offset).
    assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !row_end) |=>
            ((src_ptr - $past(src_ptr)) == (dst_ptr - $past(dst_ptr))));
endmodule

// File: rtl/blit_engine.sv
// Module: raster-op rectangle blitter top.
// Validates a start request, then walks the rectangle with three RAM cycles
// per byte (read source, read destination, write result). Assumes a RAM whose
// read data appears one cycle after an enabled read.
module blit_engine #(
    parameter int ADDR_W  = 10,
    parameter int PITCH_W = 11,
    parameter int DIM_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         rop_code,
    input  logic [7:0]         mode,
    input  logic [ADDR_W-1:0]  src_addr,
    input  logic [ADDR_W-1:0]  dst_addr,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic               busy,
    output logic               done
);
    import blit_pkg::*;

    localparam logic [2:0] MAX_PIX_CODE = 3'd3;

    blit_state_e st;
    rop_dec_t    dec;
    logic [3:0]  tt_q;
    logic [7:0]  src_q;
    logic        accept, refuse, load, step, last;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;

    // Request checks: known code, supported pixel size, non-empty rectangle.
    always_comb begin
        dec    = rop_decode(rop_code);
        accept = (st == ST_IDLE) && start && dec.known &&
                 (mode[3:1] <= MAX_PIX_CODE) && (width != '0) && (height != '0);
        refuse = (st == ST_IDLE) && start && !accept;
        load   = accept;
        step   = (st == ST_WRITE);
    end

    blit_walker #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .backward(mode[0]),
        .src_base(src_addr), .dst_base(dst_addr),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch),
        .width(width), .height(height),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .last(last)
    );

    blit_rop_alu #(.DATA_W(BYTE_W)) u_alu (
        .table_bits(tt_q), .src_byte(src_q), .dst_byte(mem_rdata), .result(mem_wdata)
    );

    // Per-byte sequencer, operation latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; tt_q <= '0; src_q <= '0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        tt_q <= dec.table_bits;
                        st   <= ST_RSRC;
                    end else if (refuse) begin
                        done <= 1'b1;
                    end
                end
                ST_RSRC: st <= ST_RDST;
                ST_RDST: begin
                    src_q <= mem_rdata;
                    st    <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (last) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= ST_RSRC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // RAM port drive from the sequencer state.
    always_comb begin
        busy     = (st != ST_IDLE);
        mem_en   = busy;
        mem_we   = (st == ST_WRITE);
        mem_addr = (st == ST_RSRC) ? src_ptr : dst_ptr;
    end

    // Refused codes finish next cycle without a transfer.
    assert_refuse_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !rop_decode(rop_code).known) |=> (done && !mem_en));

    // Pixel size codes above 3 are refused.
    assert_refuse_pix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode[3:1] > MAX_PIX_CODE) |=> (done && !mem_en));

    // Empty rectangles finish with no access.
    assert_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (width == '0 || height == '0)) |=> (done && !mem_en));

    // A write is always followed by a non-write cycle (three phases per byte).
    assert_write_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // done is a one-cycle pulse outside the busy window.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_en));

    // A start while busy does not alter the latched operation.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tt_q));
endmodule

// File: tb/blit_engine_tb.sv
// Scoreboard bench: the driver predicts every RAM access into a queue and the
// monitor pops and compares each access the design makes.
module blit_engine_tb;
    localparam int ADDR_W = 10, PITCH_W = 11, DIM_W = 6;
    localparam int MSZ = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] rop_code = '0, mode = '0;
    logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0;
    logic [PITCH_W-1:0] src_pitch = '0, dst_pitch = '0;
    logic [DIM_W-1:0] width = '0, height = '0;
    logic mem_en, mem_we, busy, done;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    logic [7:0] ram [MSZ];
    logic [7:0] refm [MSZ];
    logic [18:0] expq [$];
    int checks = 0, errors = 0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    blit_engine #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rop_code(rop_code), .mode(mode),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_pitch(src_pitch),
        .dst_pitch(dst_pitch), .width(width), .height(height),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    // Synchronous RAM model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else mem_rdata <= ram[mem_addr];
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop one predicted access per access observed.
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (expq.size() == 0) begin
                check(cur_req, 1'b0, {mem_we, mem_addr}, 0);
            end else begin
                logic [18:0] e;
                logic [18:0] a;
                e = expq.pop_front();
                a = {mem_we, mem_addr, mem_we ? mem_wdata : 8'h00};
                check(cur_req, a == e, int'(a), int'(e));
            end
        end
    end

    function automatic logic [7:0] rop_ref(input logic [7:0] c, input logic [7:0] s, input logic [7:0] d);
        case (c)
            8'h00: return 8'h00;          8'h05: return s & d;
            8'h06: return d;              8'h09: return s & ~d;
            8'h0B: return ~d;             8'h0D: return s;
            8'h0E: return 8'hFF;          8'h50: return ~s & d;
            8'h59: return s ^ d;          8'h6D: return s | d;
            8'h90: return ~s | ~d;        8'h95: return ~(s ^ d);
            8'hAD: return s | ~d;         8'hD0: return ~s;
            8'hD6: return ~s | d;         default: return ~s & ~d;
        endcase
    endfunction

    function automatic bit rop_known(input logic [7:0] c);
        case (c)
            8'h00, 8'h05, 8'h06, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50,
            8'h59, 8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic fill_ram(input int seed);
        for (int i = 0; i < MSZ; i++) begin
            ram[i] = 8'((i * 37 + seed * 11) ^ (i >> 3));
            refm[i] = ram[i];
        end
    endtask

    // Driver: predict accesses, pulse start, time done, compare memory.
    task automatic run_blit(input string req, input logic [7:0] code, input logic [7:0] md,
                            input int sa, input int da, input int sp, input int dp,
                            input int w, input int h, input bit poke);
        bit acc;
        int n, nexp, sr, dr;
        acc = rop_known(code) && (md[3:1] <= 3) && w > 0 && h > 0;
        cur_req = req;
        if (acc) begin
            sr = sa; dr = da;
            for (int y = 0; y < h; y++) begin
                for (int x = 0; x < w; x++) begin
                    int s, d;
                    logic [7:0] r;
                    s = md[0] ? (sr - x) & (MSZ-1) : (sr + x) & (MSZ-1);
                    d = md[0] ? (dr - x) & (MSZ-1) : (dr + x) & (MSZ-1);
                    r = rop_ref(code, refm[s], refm[d]);
                    expq.push_back({1'b0, ADDR_W'(s), 8'h00});
                    expq.push_back({1'b0, ADDR_W'(d), 8'h00});
                    expq.push_back({1'b1, ADDR_W'(d), r});
                    refm[d] = r;
                end
                sr = md[0] ? (sr - sp) & (MSZ-1) : (sr + sp) & (MSZ-1);
                dr = md[0] ? (dr - dp) & (MSZ-1) : (dr + dp) & (MSZ-1);
            end
        end
        nexp = acc ? 3 * w * h + 1 : 1;
        @(negedge clk);
        rop_code = code; mode = md; src_addr = ADDR_W'(sa); dst_addr = ADDR_W'(da);
        src_pitch = PITCH_W'(sp); dst_pitch = PITCH_W'(dp);
        width = DIM_W'(w); height = DIM_W'(h); start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (n == 1) check("R9", busy == acc, busy, acc);
            if (poke && n == 4) begin
                start = 1'b1; rop_code = 8'h00; width = DIM_W'(2); height = DIM_W'(1);
            end
        end while (!done && n < 2000);
        start = 1'b0;
        check(req, n == nexp, n, nexp);
        @(negedge clk);
        check("R9", done == 1'b0 && busy == 1'b0, done, 0);
        check(req, expq.size() == 0, expq.size(), 0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < MSZ; i++) if (ram[i] !== refm[i]) bad++;
            check(req, bad == 0, bad, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 1'b0, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] codes [16];
        codes = '{8'h00, 8'h05, 8'h06, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50,
                  8'h59, 8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA};
        fill_ram(1);
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset
        check("R11", {busy, done, mem_en, mem_we} == 4'b0, {busy, done, mem_en, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {busy, done, mem_en, mem_we} == 4'b0, {busy, done, mem_en, mem_we}, 0);

        // R1 and R8: every code over all four bit pairings (src 0x0F/0x33, dst 0x55/0x33)
        for (int k = 0; k < 16; k++) begin
            fill_ram(k);
            ram[16] = 8'h0F; ram[17] = 8'h33; ram[18] = 8'hC3; ram[19] = 8'hF0;
            ram[96] = 8'h55; ram[97] = 8'h33; ram[98] = 8'hA5; ram[99] = 8'h0F;
            for (int i = 16; i < 20; i++) refm[i] = ram[i];
            for (int i = 96; i < 100; i++) refm[i] = ram[i];
            run_blit(codes[k] == 8'h06 ? "R8" : "R1", codes[k], 8'h00, 16, 96, 0, 0, 4, 1, 1'b0);
        end

        // R6: forward multi-row copy, positive pitches
        fill_ram(3);
        run_blit("R6", 8'h0D, 8'h02, 40, 300, 16, 20, 5, 3, 1'b0);
        // R6: negative pitch with wrap below address 0
        fill_ram(4);
        run_blit("R6", 8'h59, 8'h04, 500, 20, -32, -24, 3, 4, 1'b0);
        // R7: backward walk with negated pitches
        fill_ram(5);
        run_blit("R7", 8'h6D, 8'h01, 200, 700, 16, 32, 4, 3, 1'b0);
        // R7: overlapping backward shift by two bytes
        fill_ram(6);
        run_blit("R7", 8'h0D, 8'h07, 120, 122, 10, 10, 6, 2, 1'b0);
        // R5: single byte timing
        fill_ram(7);
        run_blit("R5", 8'h95, 8'h00, 1, 2, 0, 0, 1, 1, 1'b0);
        // R2: unknown codes refused
        run_blit("R2", 8'h07, 8'h00, 0, 64, 8, 8, 3, 3, 1'b0);
        run_blit("R2", 8'hFF, 8'h00, 0, 64, 8, 8, 3, 3, 1'b0);
        // R3: pixel code 5 refused, code 3 accepted
        run_blit("R3", 8'h0D, 8'h0A, 0, 64, 8, 8, 3, 3, 1'b0);
        run_blit("R3", 8'h0D, 8'h06, 0, 64, 8, 8, 3, 2, 1'b0);
        // R4: empty rectangles
        run_blit("R4", 8'h0D, 8'h00, 0, 64, 8, 8, 0, 3, 1'b0);
        run_blit("R4", 8'h0D, 8'h00, 0, 64, 8, 8, 3, 0, 1'b0);
        // R10: start pulse during a transfer is ignored
        fill_ram(8);
        run_blit("R10", 8'h50, 8'h00, 10, 400, 8, 8, 4, 2, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule